// File: doc/BRIEF.md
# Linked-List Command Block Walker

This block walks a chain of command blocks held in main memory and forwards the payload of each block, word by word, to a graphics command input. Every block starts with a single header word that carries both the number of payload words that follow it and the link to the next block. The walk ends when the link about to be followed has its end-marker bit set. The walk does not end on a null pointer.

A start strobe loads the first link. The walker then alternates between single-word memory reads (a request held until a data-valid response) and a valid/ready stream toward the command port. It stalls whenever that port is not ready. For every block it adds an estimated cycle cost to a running counter. If the chain keeps going past a fixed node budget, the walker treats it as a probable loop, abandons the walk and flags an error. Either way a single-cycle done pulse closes the walk, and the cost and error results stay visible until the next start.

Top module: `lw_chain_walker`

## Requirements
- R1: After reset the walker is idle: mem_req, cmd_valid, done and abort_err are 0 and cost is 0. While idle, neither mem_req nor cmd_valid is raised.
- R2: The header word is split as follows. Bits 31:24 are the payload length in words, and bits 23:0 are the link to the next block. A length of 0 is legal and forwards no payload word for that block.
- R3: A link with bit 23 set terminates the walk before that link is read. A start whose first link already has bit 23 set issues no memory read and finishes with cost 0.
- R4: Memory reads use byte addresses made from link bits 20:2 with bits 1:0 forced to zero. Link bits 22:21 are ignored. The payload words sit at the consecutive word addresses after the header and wrap within the 2 MB space.
- R5: Payload words reach cmd_data in memory order, one per cycle with both cmd_valid and cmd_ready high. While cmd_ready is low, cmd_valid stays high and cmd_data stays unchanged.
- R6: Each visited block adds 10 to cost, plus 5 plus its length when the length is nonzero. cost holds its value while idle and is cleared only by an accepted start.
- R7: When NODE_LIMIT blocks have been visited and the next link is not terminal, the walk aborts with abort_err set. A chain of exactly NODE_LIMIT blocks ends cleanly. abort_err is cleared by the next accepted start.
- R8: done is a one-cycle pulse raised in the first idle cycle after a walk ends, for both a clean end and an abort.
- R9: A start strobe while the walker is busy is ignored; the running walk and its results are unchanged.
- R10: mem_req, once raised, stays high with an unchanged mem_addr until a cycle with mem_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (honoured only when idle) |
| start_link | input | 24 | First link of the chain |
| mem_req | output | 1 | Word read request |
| mem_addr | output | MEM_AW | Byte address of the requested word |
| mem_valid | input | 1 | Read data returned this cycle |
| mem_rdata | input | 32 | Read data word |
| cmd_valid | output | 1 | Payload word available |
| cmd_data | output | 32 | Payload word |
| cmd_ready | input | 1 | Command port accepts the word |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| abort_err | output | 1 | Last walk hit the node budget |
| cost | output | COST_W | Accumulated cycle-cost estimate |

## Verification
The end-marker test and the node-budget test can become true in the same cycle, when the link reached after exactly NODE_LIMIT blocks is itself terminal. The bench provokes this case with a chain of exactly NODE_LIMIT zero-length blocks, which must end cleanly with cost 10 times NODE_LIMIT. It also runs a self-looping block, which must abort with the same cost. A second collision pairs a start strobe with a walk in progress: the bench pulses start mid-walk and requires the original payload stream and cost to come out unchanged. Payload order is judged by a scoreboard while cmd_ready is withdrawn irregularly.

// File: rtl/lw_pkg.sv
package lw_pkg;

    localparam int WORD_W            = 32;
    localparam int LEN_W             = 8;
    localparam int LINK_W            = 24;
    localparam int END_BIT           = 23;
    localparam int NODE_BASE_COST    = 10;
    localparam int PAYLOAD_BASE_COST = 5;
    localparam int NODE_COST_W       = LEN_W + 2;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [LINK_W-1:0] link;
    } hdr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TEST,
        ST_HDR,
        ST_FETCH,
        ST_SEND
    } walk_st_t;

    function automatic logic [NODE_COST_W-1:0] node_cost(input logic [LEN_W-1:0] len);
        logic [NODE_COST_W-1:0] c;
        c = NODE_COST_W'(NODE_BASE_COST);
        if (len != '0)
            c = c + NODE_COST_W'(PAYLOAD_BASE_COST) + NODE_COST_W'(len);
        return c;
    endfunction

    function automatic logic link_ends(input logic [LINK_W-1:0] link);
        return link[END_BIT];
    endfunction

endpackage

// File: rtl/lw_fetch_ptr.sv
module lw_fetch_ptr #(
    parameter int MEM_AW = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [MEM_AW-1:0] load_addr,
    input  logic              step,
    output logic [MEM_AW-1:0] byte_addr
);
    localparam int WP_W = MEM_AW - 2;

    logic [WP_W-1:0] wp_q;

    always_ff @(posedge clk) begin
        if (rst)
            wp_q <= '0;
        else if (load)
            wp_q <= load_addr[MEM_AW-1:2];
        else if (step)
            wp_q <= wp_q + 1'b1;
    end

    assign byte_addr = {wp_q, 2'b00};

endmodule

// File: rtl/lw_cost_acc.sv
module lw_cost_acc
    import lw_pkg::*;
#(
    parameter int COST_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              add,
    input  logic [LEN_W-1:0]  len,
    output logic [COST_W-1:0] cost
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            cost <= '0;
        else if (add)
            cost <= cost + COST_W'(node_cost(len));
    end

endmodule

// File: rtl/lw_node_guard.sv
module lw_node_guard #(
    parameter int NODE_LIMIT = 8192
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CNT_W = $clog2(NODE_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(NODE_LIMIT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (inc && cnt_q != LIMIT_V)
            cnt_q <= cnt_q + 1'b1;
    end

    assign at_limit = (cnt_q == LIMIT_V);

endmodule

// File: rtl/lw_chain_walker.sv
module lw_chain_walker
    import lw_pkg::*;
#(
    parameter int MEM_AW     = 21,
    parameter int COST_W     = 32,
    parameter int NODE_LIMIT = 8192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LINK_W-1:0] start_link,
    output logic              mem_req,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              cmd_valid,
    output logic [WORD_W-1:0] cmd_data,
    input  logic              cmd_ready,
    output logic              busy,
    output logic              done,
    output logic              abort_err,
    output logic [COST_W-1:0] cost
);
    walk_st_t          st_q, st_d;
    logic [LINK_W-1:0] link_q;
    logic [LEN_W-1:0]  left_q;
    logic [WORD_W-1:0] word_q;
    logic              done_q;
    logic              err_q;
    hdr_t              hdr;

    logic ptr_load, ptr_step, cost_add, walk_clr, guard_hit;
    logic end_now, abort_now;

    assign hdr = hdr_t'(mem_rdata);

    always_comb begin
        st_d      = st_q;
        ptr_load  = 1'b0;
        ptr_step  = 1'b0;
        cost_add  = 1'b0;
        walk_clr  = 1'b0;
        end_now   = 1'b0;
        abort_now = 1'b0;
        mem_req   = 1'b0;
        cmd_valid = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    walk_clr = 1'b1;
                    st_d     = ST_TEST;
                end
            end
            ST_TEST: begin
                if (link_ends(link_q)) begin
                    end_now = 1'b1;
                    st_d    = ST_IDLE;
                end else if (guard_hit) begin
                    abort_now = 1'b1;
                    st_d      = ST_IDLE;
                end else begin
                    ptr_load = 1'b1;
                    st_d     = ST_HDR;
                end
            end
            ST_HDR: begin
                mem_req = 1'b1;
                if (mem_valid) begin
                    cost_add = 1'b1;
                    ptr_step = 1'b1;
                    st_d     = (hdr.len == '0) ? ST_TEST : ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_req = 1'b1;
                if (mem_valid)
                    st_d = ST_SEND;
            end
            ST_SEND: begin
                cmd_valid = 1'b1;
                if (cmd_ready) begin
                    ptr_step = 1'b1;
                    st_d     = (left_q == LEN_W'(1)) ? ST_TEST : ST_FETCH;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            link_q <= '0;
            left_q <= '0;
            word_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= end_now || abort_now;
            if (walk_clr) begin
                link_q <= start_link;
                err_q  <= 1'b0;
            end
            if (abort_now)
                err_q <= 1'b1;
            if (st_q == ST_HDR && mem_valid) begin
                link_q <= hdr.link;
                left_q <= hdr.len;
            end
            if (st_q == ST_FETCH && mem_valid)
                word_q <= mem_rdata;
            if (st_q == ST_SEND && cmd_ready)
                left_q <= left_q - 1'b1;
        end
    end

    lw_fetch_ptr #(.MEM_AW(MEM_AW)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load      (ptr_load),
        .load_addr (link_q[MEM_AW-1:0]),
        .step      (ptr_step),
        .byte_addr (mem_addr)
    );

    lw_cost_acc #(.COST_W(COST_W)) u_cost (
        .clk  (clk),
        .rst  (rst),
        .clr  (walk_clr),
        .add  (cost_add),
        .len  (hdr.len),
        .cost (cost)
    );

    lw_node_guard #(.NODE_LIMIT(NODE_LIMIT)) u_guard (
        .clk      (clk),
        .rst      (rst),
        .clr      (walk_clr),
        .inc      (cost_add),
        .at_limit (guard_hit)
    );

    assign cmd_data  = word_q;
    assign busy      = (st_q != ST_IDLE);
    assign done      = done_q;
    assign abort_err = err_q;

endmodule

// File: rtl/lw_chain_walker_chk.sv
module lw_chain_walker_chk #(
    parameter int MEM_AW = 21,
    parameter int COST_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              mem_req,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              mem_valid,
    input logic              cmd_valid,
    input logic [31:0]       cmd_data,
    input logic              cmd_ready,
    input logic              busy,
    input logic              done,
    input logic              abort_err,
    input logic [COST_W-1:0] cost
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !cmd_valid));

    assert_addr_align_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

    assert_cost_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(cost));

    assert_err_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(abort_err) |-> done);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_end_marks_done_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

endmodule

bind lw_chain_walker lw_chain_walker_chk #(.MEM_AW(MEM_AW), .COST_W(COST_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_valid (mem_valid),
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .done      (done),
    .abort_err (abort_err),
    .cost      (cost)
);

// File: tb/lw_chain_walker_test.sv
module lw_chain_walker_test;

    localparam int MEM_AW = 21;
    localparam int COST_W = 32;
    localparam int LIMIT  = 8192;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [23:0]       start_link = '0;
    logic              mem_req;
    logic [MEM_AW-1:0] mem_addr;
    logic              mem_valid = 1'b0;
    logic [31:0]       mem_rdata = '0;
    logic              cmd_valid;
    logic [31:0]       cmd_data;
    logic              cmd_ready = 1'b1;
    logic              busy, done, abort_err;
    logic [COST_W-1:0] cost;

    logic [31:0] mem [int];
    logic [31:0] exp_q [$];
    int  checks = 0;
    int  fails  = 0;
    int  rd_cnt = 0;
    bit  stall_on = 1'b0;
    bit  finished = 1'b0;

    lw_chain_walker #(.MEM_AW(MEM_AW), .COST_W(COST_W), .NODE_LIMIT(LIMIT)) uut (
        .clk(clk), .rst(rst), .start(start), .start_link(start_link),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .busy(busy), .done(done), .abort_err(abort_err), .cost(cost)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model: one-cycle read latency, one response per request
    always @(posedge clk) begin
        if (rst) begin
            mem_valid <= 1'b0;
        end else begin
            mem_valid <= mem_req && !mem_valid;
            if (mem.exists(int'(mem_addr[20:2])))
                mem_rdata <= mem[int'(mem_addr[20:2])];
            else
                mem_rdata <= 32'hBAD0_0000;
            if (mem_req && mem_valid)
                rd_cnt <= rd_cnt + 1;
        end
    end

    // monitor: drives cmd_ready, pops scoreboard on each handshake
    always @(negedge clk) begin
        if (!rst) begin
            cmd_ready = stall_on ? (($urandom % 3) != 0) : 1'b1;
            if (cmd_valid && cmd_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected payload word", cmd_data, 0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check(cmd_data == e, "R5 payload order", cmd_data, e);
                end
            end
        end
    end

    task automatic put_node(input int widx, input int len, input logic [23:0] link,
                            input logic [31:0] seed);
        mem[widx] = {len[7:0], link};
        for (int k = 0; k < len; k++) begin
            mem[(widx + 1 + k) & 32'h7FFFF] = seed + k;
            exp_q.push_back(seed + k);
        end
    endtask

    task automatic run_walk(input logic [23:0] lnk, input int poke_at,
                            output bit ok, output logic [COST_W-1:0] c, output logic e);
        int cyc;
        ok = 1'b0;
        c  = '0;
        e  = 1'b0;
        @(negedge clk);
        start      = 1'b1;
        start_link = lnk;
        @(negedge clk);
        start      = 1'b0;
        start_link = 24'h800000;
        cyc = 0;
        while (cyc < 60000) begin
            if (done) begin
                ok = 1'b1;
                c  = cost;
                e  = abort_err;
                break;
            end
            start = (cyc == poke_at);
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        if (!ok)
            check(1'b0, "R8 walk timeout", 0, 1);
        @(negedge clk);
        check(!done, "R8 done single pulse", done, 0);
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            check(1'b0, "R8 global watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        bit ok;
        logic [COST_W-1:0] c;
        logic e;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!mem_req,   "R1 mem_req after reset", mem_req, 0);
        check(!cmd_valid, "R1 cmd_valid after reset", cmd_valid, 0);
        check(!done,      "R1 done after reset", done, 0);
        check(!abort_err, "R1 abort_err after reset", abort_err, 0);
        check(cost == 0,  "R1 cost after reset", cost, 0);

        // R3: terminal first link, no reads
        rd_cnt = 0;
        run_walk(24'h800000, -1, ok, c, e);
        check(c == 0,      "R3 cost for empty chain", c, 0);
        check(rd_cnt == 0, "R3 no memory read", rd_cnt, 0);
        check(!e,          "R3 no error", e, 0);

        // R2, R5, R6: three blocks, one of length zero, stalled port
        mem.delete();
        stall_on = 1'b1;
        put_node(32'h400, 2, 24'h002000, 32'hA000_0000);
        put_node(32'h800, 0, 24'h000400, 32'h0);
        put_node(32'h100, 3, 24'hFF0000, 32'hC000_0000);
        run_walk(24'h001000, -1, ok, c, e);
        check(c == 45,            "R6 cost of three blocks", c, 45);
        check(exp_q.size() == 0,  "R2 all payload forwarded", exp_q.size(), 0);
        check(!e,                 "R2 clean end", e, 0);
        repeat (5) @(negedge clk);
        check(cost == 45,         "R6 cost held while idle", cost, 45);

        // R4: ignored high link bits and wrap at top of 2 MB
        mem.delete();
        exp_q.delete();
        put_node(32'h7FFFE, 3, 24'h8ABCDE, 32'h5500_0000);
        run_walk(24'h7FFFF8, -1, ok, c, e);
        check(c == 18,           "R4 cost of wrapped block", c, 18);
        check(exp_q.size() == 0, "R4 wrapped payload forwarded", exp_q.size(), 0);

        // R9: start pulse mid-walk ignored
        mem.delete();
        exp_q.delete();
        put_node(32'h400, 2, 24'h002000, 32'hA100_0000);
        put_node(32'h800, 0, 24'h000400, 32'h0);
        put_node(32'h100, 3, 24'hFF0000, 32'hC100_0000);
        run_walk(24'h001000, 4, ok, c, e);
        check(c == 45,           "R9 cost unaffected by start", c, 45);
        check(exp_q.size() == 0, "R9 payload unaffected by start", exp_q.size(), 0);
        stall_on = 1'b0;

        // R7: exactly LIMIT blocks end cleanly
        mem.delete();
        exp_q.delete();
        for (int i = 0; i < LIMIT; i++)
            put_node(32'h10000 + i, 0,
                     (i == LIMIT - 1) ? 24'h800000 : 24'((32'h10000 + i + 1) * 4), 32'h0);
        run_walk(24'h040000, -1, ok, c, e);
        check(!e,              "R7 exact budget no error", e, 0);
        check(c == 10 * LIMIT, "R7 exact budget cost", c, 10 * LIMIT);

        // R7: self loop aborts
        mem.delete();
        put_node(32'h40, 0, 24'h000100, 32'h0);
        run_walk(24'h000100, -1, ok, c, e);
        check(e,               "R7 loop aborts with error", e, 1);
        check(c == 10 * LIMIT, "R7 loop cost", c, 10 * LIMIT);

        // R7: next start clears the error
        run_walk(24'h800000, -1, ok, c, e);
        check(!e, "R7 error cleared by start", e, 0);
        check(c == 0, "R6 cost cleared by start", c, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule